// File: doc/BRIEF.md
# Frame List Schedule Walker

This block is the periodic scheduling engine of a simple full/low speed USB host controller. A page-aligned base register and a frame counter that advances once per millisecond choose one 32-bit entry of a 1024-entry frame list held in memory. At the start of each frame the walker fetches that entry and follows the link pointers it finds through queue heads and transfer descriptors. Each active descriptor is "executed": bus signalling is abstracted as a fixed number of cycles. The walker then writes the descriptor's control word back with the active bit cleared and a done bit set.

A descriptor flagged for interrupt-on-completion sets a sticky interrupt bit, and software clears it with a one-cycle clear pulse. Software that does not use the interrupt can poll the done bit in memory instead. The frame budget is a hard limit. When the millisecond ends while the walk is still under way, the walk is abandoned and the next entry is fetched. A descriptor that was cut short stays active and is retried in a later frame. Memory is reached through one synchronous port: read data returns the cycle after the request. A `run` input starts and halts the schedule.

Top module: `sched_walker`

## Requirements
- R1: After reset `irq` is 0 and `frame_idx` is 0. While `run` is low, `mem_req` stays low.
- R2: Each frame begins with a read of address {base[31:12], frame_idx, 2'b00}. The base is written with `base_we`, and bits 11:0 of `base_wdata` are ignored.
- R3: While `run` is high, `frame_idx` advances by one every FRAME_CYCLES cycles and wraps from 1023 to 0. It never changes by any other step.
- R4: Link pointer format: bit 0 set means terminate, bit 1 set means queue head (clear means descriptor), and bits 31:4 hold the 16-byte aligned address. A terminate pointer ends the walk for that frame with no further memory access.
- R5: A queue head keeps its horizontal link at +0 and its element pointer at +4. The element chain is walked first, then the horizontal link. The horizontal link is also taken directly when the element pointer terminates.
- R6: A descriptor keeps its link at +0 and its control word at +4. When control bit 31 (active) is set, the walker waits EXEC_LAT cycles and then writes +4 with bit 31 cleared, bit 29 (done) set, and all other bits unchanged. An inactive descriptor is not written, and the walk continues with its link.
- R7: The completion write of a descriptor whose control bit 30 (interrupt-on-completion) is set also sets `irq` on the following clock edge.
- R8: `irq` holds until a cycle with `irq_clr` high clears it. When a completion with bit 30 set falls in the same cycle as `irq_clr`, `irq` stays set.
- R9: When the frame time expires, the walk is abandoned even inside a loop of descriptors. The next cycle starts the next frame's entry fetch.
- R10: From the cycle after `run` is sampled low, no memory request is issued and `frame_idx` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Schedule enable |
| base_we | input | 1 | Load the frame list base |
| base_wdata | input | 32 | New base address (bits 31:12 kept) |
| irq_clr | input | 1 | Clears the interrupt bit |
| irq | output | 1 | Sticky completion interrupt |
| frame_idx | output | 10 | Current frame number |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The irq set path and the software clear can land in the same cycle. The bench waits for the completion write of an interrupt-flagged descriptor to show on the memory port, then raises `irq_clr` in that very cycle, and it expects `irq` to still read 1 one cycle later. A second coincidence is frame expiry against a walk that never ends on its own. A descriptor ring that loops back on itself keeps the walker busy, and the bench judges that the next frame's entry read still appears and that the ring's single active descriptor is written exactly once.

// File: rtl/sw_pkg.sv
package sw_pkg;
    // link pointer fields
    localparam int PTR_T_BIT = 0;
    localparam int PTR_Q_BIT = 1;
    // descriptor control word fields
    localparam int CTL_ACTIVE = 31;
    localparam int CTL_IOC    = 30;
    localparam int CTL_DONE   = 29;
    // word offsets inside a queue head or descriptor
    localparam int LINK_OFS = 0;
    localparam int BODY_OFS = 4;

    typedef enum logic [3:0] {
        S_STOP, S_ENTRY, S_LINK, S_PTR, S_QH_LINK, S_QH_ELEM,
        S_TD_CTRL, S_EXEC, S_TD_RD, S_TD_LINK, S_IDLE
    } walk_st_e;
endpackage

// File: rtl/sw_frame_timer.sv
module sw_frame_timer #(
    parameter int FRAME_CYCLES = 48000,
    parameter int IDX_W        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic             expire,
    output logic [IDX_W-1:0] idx
);
    localparam int TMR_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [IDX_W-1:0] idx;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        expire = run && (r_q.tmr == TMR_W'(FRAME_CYCLES - 1));
        if (!run) begin
            r_d.tmr = '0;
        end else if (expire) begin
            r_d.tmr = '0;
            r_d.idx = r_q.idx + IDX_W'(1);
        end else begin
            r_d.tmr = r_q.tmr + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign idx = r_q.idx;
endmodule

// File: rtl/sw_link_decode.sv
module sw_link_decode #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic [DW-1:0] link,
    output logic          term,
    output logic          is_qh,
    output logic [AW-1:0] addr
);
    import sw_pkg::*;
    logic unused_rsvd;
    assign unused_rsvd = ^link[3:2];
    assign term  = link[PTR_T_BIT];
    assign is_qh = link[PTR_Q_BIT];
    assign addr  = {link[AW-1:4], 4'b0000};
endmodule

// File: rtl/sched_walker.sv
module sched_walker #(
    parameter int AW           = 32,
    parameter int DW           = 32,
    parameter int IDX_W        = 10,
    parameter int FRAME_CYCLES = 48000,
    parameter int EXEC_LAT     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             base_we,
    input  logic [AW-1:0]    base_wdata,
    input  logic             irq_clr,
    output logic             irq,
    output logic [IDX_W-1:0] frame_idx,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);
    import sw_pkg::*;

    localparam int PAGE_W = AW - IDX_W - 2;
    localparam int CNT_W  = (EXEC_LAT > 1) ? $clog2(EXEC_LAT) : 1;

    typedef struct packed {
        walk_st_e         st;
        logic [PAGE_W-1:0] base;
        logic [DW-1:0]    ptr;
        logic [AW-1:0]    cur;
        logic [DW-1:0]    qh_link;
        logic             in_qh;
        logic [DW-1:0]    ctrl;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } walk_t;

    walk_t r_q, r_d;
    logic  expire;
    logic  set_irq;
    logic  p_term, p_qh;
    logic [AW-1:0] p_addr;
    logic  unused_base_lo;

    assign unused_base_lo = ^base_wdata[AW-PAGE_W-1:0];

    sw_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES), .IDX_W(IDX_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(run), .expire(expire), .idx(frame_idx)
    );

    sw_link_decode #(.DW(DW), .AW(AW)) u_dec (
        .link(r_q.ptr), .term(p_term), .is_qh(p_qh), .addr(p_addr)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        set_irq   = 1'b0;
        if (base_we) r_d.base = base_wdata[AW-1:AW-PAGE_W];

        case (r_q.st)
            S_STOP: if (run) r_d.st = S_ENTRY;
            S_ENTRY: begin
                mem_req  = 1'b1;
                mem_addr = {r_q.base, frame_idx, 2'b00};
                r_d.st   = S_LINK;
            end
            S_LINK: begin
                r_d.ptr   = mem_rdata;
                r_d.in_qh = 1'b0;
                r_d.st    = S_PTR;
            end
            S_PTR: begin
                if (p_term) begin
                    r_d.st = S_IDLE;
                end else begin
                    mem_req = 1'b1;
                    r_d.cur = p_addr;
                    if (p_qh) begin
                        mem_addr = p_addr + AW'(LINK_OFS);
                        r_d.st   = S_QH_LINK;
                    end else begin
                        mem_addr = p_addr + AW'(BODY_OFS);
                        r_d.st   = S_TD_CTRL;
                    end
                end
            end
            S_QH_LINK: begin
                r_d.qh_link = mem_rdata;
                mem_req     = 1'b1;
                mem_addr    = r_q.cur + AW'(BODY_OFS);
                r_d.st      = S_QH_ELEM;
            end
            S_QH_ELEM: begin
                if (mem_rdata[PTR_T_BIT]) begin
                    r_d.ptr   = r_q.qh_link;
                    r_d.in_qh = 1'b0;
                end else begin
                    r_d.ptr   = mem_rdata;
                    r_d.in_qh = 1'b1;
                end
                r_d.st = S_PTR;
            end
            S_TD_CTRL: begin
                r_d.ctrl = mem_rdata;
                if (mem_rdata[CTL_ACTIVE]) begin
                    r_d.cnt = CNT_W'(EXEC_LAT - 1);
                    r_d.st  = S_EXEC;
                end else begin
                    r_d.st  = S_TD_RD;
                end
            end
            S_EXEC: begin
                if (r_q.cnt == '0) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = r_q.cur + AW'(BODY_OFS);
                    mem_wdata = r_q.ctrl;
                    mem_wdata[CTL_ACTIVE] = 1'b0;
                    mem_wdata[CTL_DONE]   = 1'b1;
                    set_irq   = r_q.ctrl[CTL_IOC];
                    r_d.st    = S_TD_RD;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_TD_RD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + AW'(LINK_OFS);
                r_d.st   = S_TD_LINK;
            end
            S_TD_LINK: begin
                if (mem_rdata[PTR_T_BIT] && r_q.in_qh) begin
                    r_d.ptr   = r_q.qh_link;
                    r_d.in_qh = 1'b0;
                end else begin
                    r_d.ptr   = mem_rdata;
                end
                r_d.st = S_PTR;
            end
            S_IDLE: r_d.st = S_IDLE;
            default: r_d.st = S_STOP;
        endcase

        if (!run || expire) begin
            r_d.st  = run ? S_ENTRY : S_STOP;
            mem_req = 1'b0;
            mem_we  = 1'b0;
            set_irq = 1'b0;
        end

        r_d.irq = set_irq | (r_q.irq & ~irq_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_STOP;
        end else begin
            r_q    <= r_d;
        end
    end

    assign irq = r_q.irq;
endmodule

module sched_walker_chk #(
    parameter int AW    = 32,
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             irq_clr,
    input logic             irq,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [IDX_W-1:0] frame_idx
);
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !mem_we) |=> !irq);
    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_we));
    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx != $past(frame_idx)) |-> (frame_idx == $past(frame_idx) + IDX_W'(1)));
    // R10
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mem_req);
    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(frame_idx));
    // R6
    write_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_addr[1:0] == 2'b00));
endmodule

bind sched_walker sched_walker_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .irq_clr(irq_clr), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .frame_idx(frame_idx)
);

// File: tb/sim_sched_walker.sv
module sim_sched_walker;
    localparam int FC = 40;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, base_we = 1'b0, irq_clr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic irq, mem_req, mem_we;
    logic [9:0]  frame_idx;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sched_walker #(.FRAME_CYCLES(FC), .EXEC_LAT(3)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .base_we(base_we), .base_wdata(base_wdata),
        .irq_clr(irq_clr), .irq(irq), .frame_idx(frame_idx), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem [0:2047];
    always @(posedge clk) if (mem_req) begin
        if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[12:2]];
    end

    int compared = 0, mismatched = 0, pops = 0;
    int entry_cnt [1024];
    int other_cnt [1024];
    bit saw_304_late = 1'b0;
    bit finished = 1'b0;
    logic [63:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
        exp_q.push_back({a, d});
    endtask

    // scoreboard monitor and read observer
    always @(negedge clk) if (rst_n && mem_req) begin
        if (mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected write addr", mem_addr, 32'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                pops++;
                chk(mem_addr == e[63:32], "R6 write addr", mem_addr, e[63:32]);
                chk(mem_wdata == e[31:0], "R6 write data", mem_wdata, e[31:0]);
            end
        end else if (mem_addr[31:12] == 20'h00001) begin
            chk(mem_addr == {20'h00001, frame_idx, 2'b00}, "R2 entry addr", mem_addr,
                {20'h00001, frame_idx, 2'b00});
            entry_cnt[frame_idx]++;
        end else begin
            other_cnt[frame_idx]++;
            if (mem_addr == 32'h304 && pops >= 2) saw_304_late = 1'b1;
        end
    end

    task automatic wait_idx(input int v);
        while (frame_idx != 10'(v)) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        for (int i = 0; i < 1024; i++) begin
            mem[1024 + i] = 32'h1;
            entry_cnt[i] = 0;
            other_cnt[i] = 0;
        end
        mem[1024 + 0] = 32'h0000_0102;        // frame 0 -> queue head 0x100
        mem[1024 + 2] = 32'h0000_0400;        // frame 2 -> descriptor ring
        mem[1024 + 5] = 32'h0000_0500;        // frame 5 -> IOC descriptor
        mem[32'h100 >> 2] = 32'h0000_0300;  mem[32'h104 >> 2] = 32'h0000_0200;
        mem[32'h200 >> 2] = 32'h0000_0210;  mem[32'h204 >> 2] = 32'h8000_00AA;
        mem[32'h210 >> 2] = 32'h0000_0001;  mem[32'h214 >> 2] = 32'hC000_0055;
        mem[32'h300 >> 2] = 32'h0000_0001;  mem[32'h304 >> 2] = 32'h0000_0011;
        mem[32'h400 >> 2] = 32'h0000_0410;  mem[32'h404 >> 2] = 32'h8000_0077;
        mem[32'h410 >> 2] = 32'h0000_0400;  mem[32'h414 >> 2] = 32'h0000_0000;
        mem[32'h500 >> 2] = 32'h0000_0001;  mem[32'h504 >> 2] = 32'hC000_0099;
        expect_wr(32'h204, 32'h2000_00AA);
        expect_wr(32'h214, 32'h6000_0055);
        expect_wr(32'h404, 32'h2000_0077);
        expect_wr(32'h504, 32'h6000_0099);

        repeat (5) @(negedge clk);
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
        chk(frame_idx == 10'd0, "R1 frame_idx after reset", 32'(frame_idx), 0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(mem_req == 1'b0, "R1 no access while stopped", 32'(mem_req), 0);
        end
        base_we = 1'b1; base_wdata = 32'h0000_1ABC;
        @(negedge clk); base_we = 1'b0; run = 1'b1;

        wait_idx(1);
        chk(entry_cnt[0] == 1, "R2 frame 0 entry read once", 32'(entry_cnt[0]), 1);
        chk(irq == 1'b1, "R7 irq after IOC completion", 32'(irq), 1);
        chk(saw_304_late, "R5 horizontal link after element chain", 32'(saw_304_late), 1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R8 irq sticky", 32'(irq), 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 0);

        wait_idx(2);
        chk(other_cnt[1] == 0, "R4 terminate entry stops walk", 32'(other_cnt[1]), 0);
        wait_idx(4);
        chk(entry_cnt[3] == 1, "R9 next entry fetched after ring", 32'(entry_cnt[3]), 1);
        chk(other_cnt[2] > 4, "R9 ring walked until expiry", 32'(other_cnt[2]), 5);
        chk(irq == 1'b0, "R6 non-IOC completion leaves irq", 32'(irq), 0);

        wait_idx(5);
        begin
            int n = 0;
            while (!(mem_req && mem_we && mem_addr == 32'h504) && n < 200) begin
                @(negedge clk); n++;
            end
        end
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(irq == 1'b1, "R8 set wins over same-cycle clear", 32'(irq), 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(irq == 1'b0, "R8 later clear", 32'(irq), 0);

        wait_idx(1023);
        wait_idx(0);
        chk(frame_idx == 10'd0, "R3 wrap to 0", 32'(frame_idx), 0);
        wait_idx(1);
        chk(entry_cnt[0] == 2, "R2 R3 entry 0 fetched after wrap", 32'(entry_cnt[0]), 2);
        wait_idx(2);
        begin
            int n = 0;
            while (frame_idx == 10'd2) begin @(negedge clk); n++; end
            chk(n == FC, "R3 frame length", 32'(n), FC);
        end

        chk(exp_q.size() == 0, "R6 all completion writes seen", 32'(exp_q.size()), 0);
        chk(mem[32'h304 >> 2] == 32'h11, "R6 inactive descriptor untouched", mem[32'h304 >> 2], 32'h11);
        chk(mem[32'h414 >> 2] == 32'h0, "R6 inactive ring member untouched", mem[32'h414 >> 2], 32'h0);

        run = 1'b0;
        @(negedge clk);
        begin
            logic [9:0] held;
            bit quiet = 1'b1;
            held = frame_idx;
            repeat (100) begin
                @(negedge clk);
                if (mem_req || frame_idx != held) quiet = 1'b0;
            end
            chk(quiet, "R10 halted walker quiet and frozen", 32'(frame_idx), 32'(held));
        end

        finished = 1'b1;
        summary();
    end
endmodule